// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits in front of a small single-port word memory and carries out one memory operation per accepted request. Besides plain loads and stores it offers four atomic primitives: test-and-set, swap, fetch-and-add and compare-and-swap. All four share one read-modify-write datapath, and each has its own write condition and its own return value. Every request returns the word that memory held before the operation. Compare-and-swap also returns a success bit.

An atomic operation reads the addressed word in the cycle in which the request is accepted. It then writes, or does not write, the result in the following cycle. During that second cycle the request-ready output is low, so no other access can reach the memory between the read and the write. Loads and stores use a single cycle and keep ready high. Requesters use the unit as the serialisation point for locks, counters and lock-free queue heads.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o is 0 and every memory word reads as 0.
- R2: Opcode 3'b000 (load) returns the addressed word and leaves memory unchanged. resp_valid_o is 1 in the cycle after acceptance, and req_ready_o stays 1.
- R3: Opcode 3'b001 (store) writes req_opa_i to the addressed word and returns the word that was there before.
- R4: Opcode 3'b010 (test-and-set) returns the old word. It writes 1 only when the old word was 0, and otherwise leaves memory unchanged.
- R5: Opcode 3'b011 (swap) writes req_opa_i and returns the previous word.
- R6: Opcode 3'b100 (fetch-and-add) returns the old word and writes back old + req_opa_i modulo 2^DATA_W, with no overflow indication.
- R7: Opcode 3'b101 (compare-and-swap) writes req_opb_i and sets resp_ok_o to 1 when req_opa_i equals the old word. Otherwise it leaves memory unchanged and sets resp_ok_o to 0. The old word is returned in both cases.
- R8: resp_ok_o is 0 for every response that does not come from compare-and-swap.
- R9: An atomic request holds req_ready_o low for exactly the one cycle after acceptance. A request presented during that cycle is not accepted, produces no response and does not change memory.
- R10: Opcodes 3'b110 and 3'b111 behave as a load: they return the word and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | ADDR_W | Word address |
| req_opa_i | input | DATA_W | Store data, swap value, addend or expected value |
| req_opb_i | input | DATA_W | New value for compare-and-swap |
| resp_valid_o | output | 1 | Response present |
| resp_data_o | output | DATA_W | Word held before the operation |
| resp_ok_o | output | 1 | Compare-and-swap success |

## Verification
The checker watches the handshake on every cycle. It checks that ready drops for exactly one cycle after each atomic acceptance and never for longer. It checks that a response follows each acceptance and nothing else. It checks that the success bit only ever appears on a compare-and-swap response. The value semantics need the bench's scenarios and its shadow memory: the conditional writes of test-and-set and compare-and-swap, wrap-around in fetch-and-add, the returned old words, and the fact that a request blocked during the write cycle leaves memory untouched.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam logic [2:0] OP_LOAD  = 3'b000;
  localparam logic [2:0] OP_STORE = 3'b001;
  localparam logic [2:0] OP_TAS   = 3'b010;
  localparam logic [2:0] OP_SWAP  = 3'b011;
  localparam logic [2:0] OP_FAA   = 3'b100;
  localparam logic [2:0] OP_CAS   = 3'b101;

  function automatic logic is_atomic(input logic [2:0] op);
    return (op == OP_TAS) || (op == OP_SWAP) || (op == OP_FAA) || (op == OP_CAS);
  endfunction
endpackage

// File: rtl/rmw_word_store.sv
module rmw_word_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        words[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g)))            words[g] <= wdata_i;
    end
  end

  assign rdata_o = words[addr_i];
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              we_o,
  output logic [DATA_W-1:0] new_o,
  output logic              ok_o
);
  always_comb begin
    we_o  = 1'b0;
    new_o = old_i;
    ok_o  = 1'b0;
    case (op_i)
      OP_TAS: begin
        we_o  = (old_i == '0);
        new_o = DATA_W'(1);
      end
      OP_SWAP: begin
        we_o  = 1'b1;
        new_o = opa_i;
      end
      OP_FAA: begin
        we_o  = 1'b1;
        new_o = old_i + opa_i;  // wraps modulo 2^DATA_W
      end
      OP_CAS: begin
        we_o  = (old_i == opa_i);
        new_o = opb_i;
        ok_o  = (old_i == opa_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_opa_i,
  input  logic [DATA_W-1:0] req_opb_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [2:0]        op_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] opa_q_o,
  output logic [DATA_W-1:0] opb_q_o,
  output logic [DATA_W-1:0] old_q_o
);
  typedef enum logic {ST_IDLE, ST_WRITE} seq_state_e;

  seq_state_e state_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = req_valid_i && ready_o;
  assign busy_o   = (state_q == ST_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      resp_valid_o <= 1'b0;
      op_q_o       <= OP_LOAD;
      addr_q_o     <= '0;
      opa_q_o      <= '0;
      opb_q_o      <= '0;
      old_q_o      <= '0;
    end else begin
      resp_valid_o <= accept_o;
      if (accept_o) begin
        state_q  <= is_atomic(req_op_i) ? ST_WRITE : ST_IDLE;
        op_q_o   <= req_op_i;
        addr_q_o <= req_addr_i;
        opa_q_o  <= req_opa_i;
        opb_q_o  <= req_opb_i;
        old_q_o  <= rdata_i;
      end else begin
        state_q  <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_opa_i,
  input  logic [DATA_W-1:0] req_opb_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_ok_o
);
  logic              accept, busy;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q, port_addr;
  logic [DATA_W-1:0] opa_q, opb_q, old_q, rdata, port_wdata, alu_new;
  logic              alu_we, alu_ok, port_we;

  rmw_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_op_i, .req_addr_i, .req_opa_i, .req_opb_i,
    .rdata_i      (rdata),
    .ready_o      (req_ready_o),
    .accept_o     (accept),
    .busy_o       (busy),
    .resp_valid_o (resp_valid_o),
    .op_q_o       (op_q),
    .addr_q_o     (addr_q),
    .opa_q_o      (opa_q),
    .opb_q_o      (opb_q),
    .old_q_o      (old_q)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op_q),
    .old_i (old_q),
    .opa_i (opa_q),
    .opb_i (opb_q),
    .we_o  (alu_we),
    .new_o (alu_new),
    .ok_o  (alu_ok)
  );

  // single port: write cycle owns it, otherwise the incoming request
  assign port_addr  = busy ? addr_q : req_addr_i;
  assign port_we    = busy ? alu_we : (accept && (req_op_i == OP_STORE));
  assign port_wdata = busy ? alu_new : req_opa_i;

  rmw_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni,
    .addr_i  (port_addr),
    .we_i    (port_we),
    .wdata_i (port_wdata),
    .rdata_o (rdata)
  );

  assign resp_data_o = old_q;
  assign resp_ok_o   = busy && alu_ok;
endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [2:0] req_op_i,
  input logic       resp_valid_o,
  input logic       resp_ok_o
);
  logic acc;
  logic atomic_req;
  assign acc        = req_valid_i && req_ready_o;
  assign atomic_req = (req_op_i == 3'b010) || (req_op_i == 3'b011) ||
                      (req_op_i == 3'b100) || (req_op_i == 3'b101);

  // R9
  atomic_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && atomic_req) |=> !req_ready_o);
  // R9
  block_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o);
  // R2
  plain_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !atomic_req) |=> req_ready_o);
  // R2
  resp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o);
  // R9
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !resp_valid_o);
  // R8
  ok_only_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (req_op_i != 3'b101)) |=> !resp_ok_o);
endmodule

bind atomic_rmw_unit atomic_rmw_checker u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .resp_valid_o, .resp_ok_o
);

// File: tb/atomic_rmw_unit_test.sv
module atomic_rmw_unit_test;
  localparam int W = 8;
  localparam int AW = 4;
  localparam int WORDS = 1 << AW;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [2:0]    req_op_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [W-1:0]  req_opa_i = '0;
  logic [W-1:0]  req_opb_i = '0;
  logic          resp_valid_o;
  logic [W-1:0]  resp_data_o;
  logic          resp_ok_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [W-1:0] model [WORDS];

  atomic_rmw_unit #(.DATA_W(W), .ADDR_W(AW)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entered and left at a negedge with ready high
  task automatic issue(input logic [2:0] op, input logic [AW-1:0] addr,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] d, output logic ok);
    logic atomic;
    atomic = (op >= 3'b010) && (op <= 3'b101);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr;
    req_opa_i = a; req_opb_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    d  = resp_data_o;
    ok = resp_ok_o;
    chk(resp_valid_o == 1'b1, "R2 resp_valid after accept", int'(resp_valid_o), 1);
    chk(req_ready_o == !atomic, "R9 ready in second cycle", int'(req_ready_o), int'(!atomic));
    if (!req_ready_o) @(negedge clk_i);
  endtask

  task automatic load_chk(input logic [AW-1:0] addr, input string req);
    logic [W-1:0] d; logic ok;
    issue(3'b000, addr, '0, '0, d, ok);
    chk(d == model[addr], req, int'(d), int'(model[addr]));
  endtask

  initial begin
    logic [W-1:0] d;
    logic ok;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (2) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(resp_valid_o == 1'b0, "R1 no response after reset", int'(resp_valid_o), 0);
    for (int i = 0; i < WORDS; i++) load_chk(AW'(i), "R1 word zero after reset");

    // R3 stores, R2 loads
    for (int i = 0; i < WORDS; i++) begin
      issue(3'b001, AW'(i), W'(i*13+5), '0, d, ok);
      chk(d == model[i], "R3 store returns old", int'(d), int'(model[i]));
      chk(ok == 1'b0, "R8 ok on store", int'(ok), 0);
      model[i] = W'(i*13+5);
    end
    for (int i = 0; i < WORDS; i++) load_chk(AW'(i), "R2 load value");
    for (int i = 0; i < WORDS; i++) begin
      issue(3'b001, AW'(i), W'(i*13+6), '0, d, ok);
      chk(d == model[i], "R3 overwrite returns old", int'(d), int'(model[i]));
      model[i] = W'(i*13+6);
    end

    // R10 unused opcodes
    for (int o = 6; o < 8; o++) begin
      issue(3'(o), 4'd3, 8'hAA, 8'h55, d, ok);
      chk(d == model[3], "R10 unused opcode returns word", int'(d), int'(model[3]));
      chk(ok == 1'b0, "R10 R8 ok on unused opcode", int'(ok), 0);
      load_chk(4'd3, "R10 unused opcode no write");
    end

    // R4 test-and-set
    issue(3'b001, 4'd0, 8'h00, '0, d, ok); model[0] = 8'h00;
    issue(3'b010, 4'd0, '0, '0, d, ok);
    chk(d == 8'h00, "R4 tas returns 0", int'(d), 0);
    chk(ok == 1'b0, "R8 ok on tas", int'(ok), 0);
    model[0] = 8'h01; load_chk(4'd0, "R4 tas wrote 1");
    issue(3'b010, 4'd0, '0, '0, d, ok);
    chk(d == 8'h01, "R4 tas returns 1 when held", int'(d), 1);
    load_chk(4'd0, "R4 tas held unchanged");
    issue(3'b001, 4'd0, 8'h80, '0, d, ok); model[0] = 8'h80;
    issue(3'b010, 4'd0, '0, '0, d, ok);
    chk(d == 8'h80, "R4 tas returns nonzero", int'(d), 8'h80);
    load_chk(4'd0, "R4 tas nonzero no write");

    // R5 swap
    for (int v = 0; v < 256; v += 37) begin
      issue(3'b011, 4'd5, W'(v), '0, d, ok);
      chk(d == model[5], "R5 swap returns old", int'(d), int'(model[5]));
      chk(ok == 1'b0, "R8 ok on swap", int'(ok), 0);
      model[5] = W'(v);
      load_chk(4'd5, "R5 swap wrote operand");
    end

    // R6 fetch-and-add with wrap
    for (int o = 0; o < 256; o += 15) begin
      for (int k = 0; k < 5; k++) begin
        logic [W-1:0] add;
        add = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h7F :
              (k == 3) ? 8'h80 : 8'hFF;
        issue(3'b001, 4'd9, W'(o), '0, d, ok); model[9] = W'(o);
        issue(3'b100, 4'd9, add, '0, d, ok);
        chk(d == W'(o), "R6 faa returns old", int'(d), o);
        chk(ok == 1'b0, "R8 ok on faa", int'(ok), 0);
        model[9] = W'((o + int'(add)) % 256);
        load_chk(4'd9, "R6 faa sum modulo");
      end
    end

    // R7 compare-and-swap
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [W-1:0] ov, ev;
        ov = (i == 0) ? 8'h00 : (i == 1) ? 8'h01 : (i == 2) ? 8'h55 : 8'hFF;
        ev = (j == 0) ? 8'h00 : (j == 1) ? 8'h01 : (j == 2) ? 8'h55 : 8'hFF;
        issue(3'b001, 4'd12, ov, '0, d, ok); model[12] = ov;
        issue(3'b101, 4'd12, ev, ~ov, d, ok);
        chk(d == ov, "R7 cas returns old", int'(d), int'(ov));
        chk(ok == (ov == ev), "R7 cas status", int'(ok), int'(ov == ev));
        if (ov == ev) model[12] = ~ov;
        load_chk(4'd12, "R7 cas memory");
      end
    end

    // R9 request during write cycle is ignored
    req_valid_i = 1'b1; req_op_i = 3'b100; req_addr_i = 4'd7;
    req_opa_i = 8'h02; req_opb_i = '0;
    @(posedge clk_i);
    @(negedge clk_i);
    model[7] = model[7] + 8'h02;
    chk(req_ready_o == 1'b0, "R9 ready low in write cycle", int'(req_ready_o), 0);
    req_op_i = 3'b001; req_addr_i = 4'd8; req_opa_i = 8'hEE;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(resp_valid_o == 1'b0, "R9 blocked request no response", int'(resp_valid_o), 0);
    chk(req_ready_o == 1'b1, "R9 ready back", int'(req_ready_o), 1);
    load_chk(4'd8, "R9 blocked store not written");
    load_chk(4'd7, "R9 atomic still completed");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule